// File: doc/BRIEF.md
# SMBus Byte-Register Target

This block is a clocked SMBus/I2C target that holds four 8-bit control registers. It samples the open-drain clock and data lines with a fast system clock. Each line passes through a two-flop synchronizer and then a spike filter. The block finds START, repeated START and STOP from the filtered levels. It takes part on the bus only by asserting an output-enable that pulls SDA low.

Software writes a register with the Write Byte sequence and reads it back with Read Byte, at a 7-bit address taken from strap inputs. A written value is held as pending and only lands in the register file when the closing STOP is seen. A new START before that STOP throws the pending value away. A broadcast write address reaches every instance; a bit in register 2 can block it. While the block's own alert is raised, it answers the Alert Response Address with its address. It checks the bus on each bit it sends and steps aside if another responder wins.

Top module: `smb_regbank`

## Requirements
- R1: A Write Byte at the strap address (address byte with bit 0 = 0, command byte, data byte, each acknowledged by a low ninth bit) stores the data byte in the register chosen by the command, once the STOP is seen. Register n is at ctrl_regs[8n+7:8n].
- R2: Only command bits [1:0] choose the register; command bits [7:2] have no effect on which register is written or read.
- R3: Until the terminating STOP arrives, all four register outputs keep their old values, even after the data byte has been acknowledged.
- R4: A START that arrives after the data byte but before any STOP discards the pending write, and every register keeps its prior value.
- R5: A Read Byte (write-addressed command byte, repeated START, address byte with bit 0 = 1) returns the selected register on SDA, most significant bit first.
- R6: An address byte that matches nothing gets no acknowledge. The block then leaves SDA released and the registers unchanged until the next START.
- R7: The broadcast address 7'b1011110 with bit 0 = 0 is acknowledged and written like the strap address, whatever the strap address is, while register 2 bit 0 is 1.
- R8: While register 2 bit 0 is 0, a broadcast write is not acknowledged and changes no register.
- R9: The address 7'b0001100 with bit 0 = 1 is acknowledged only while alert_pending is 1. The returned byte is {strap address, 1'b1}, and alert_pending falls once all eight bits go out without loss.
- R10: If SDA reads 0 while the block sends a 1 during an alert response, the block releases SDA for the rest of the byte and alert_pending stays 1.
- R11: A pulse on either line shorter than FILT_CYC system clocks (default 7) is ignored; an SCL spike inside a data byte does not disturb the written value.
- R12: After reset every register is 0 except register 2, which is 8'h01; alert_pending and sda_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level seen on the bus clock line |
| sda_i | input | 1 | Level seen on the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_addr | input | 7 | Strapped 7-bit target address |
| alert_set | input | 1 | One-cycle pulse that raises the alert |
| alert_pending | output | 1 | Alert raised and not yet answered |
| ctrl_regs | output | 32 | The four registers, register n at bits [8n+7:8n] |

## Verification
The bench acts as bus master over a wired-AND data line and follows a model of the expected register image. It writes through the strap address and the broadcast address with command bytes whose upper bits are set and clear. This shows that only the low two bits steer the write. The bench samples the registers once before and once after the STOP, which separates commit-on-STOP from commit-on-ACK. A transfer cut by a repeated START shows that the pending value is discarded. Alert responses are run twice: once alone, to check the returned address and the alert release, and once against a second responder that drives a lower address, to check that the block backs off. A short SCL spike injected mid-byte checks the filter.

// File: rtl/smb_pkg.sv
package smb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WDAT,
      ST_ACK,
      ST_TX,
      ST_SKIP
   } smb_state_t;

   localparam logic [6:0] BCAST_ADDR = 7'b1011110;
   localparam logic [6:0] ALERT_ADDR = 7'b0001100;

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
   parameter int FILT_CYC = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int CW = $clog2(FILT_CYC + 1);

   if (FILT_CYC < 1) begin : g_bad_filt
      $error("FILT_CYC must be at least 1");
   end

   logic [1:0]    sync_q;
   logic [CW-1:0] cnt_q;
   logic          filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 2'b11;
         cnt_q  <= '0;
         filt_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[0], line_i};
         if (sync_q[1] == filt_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_CYC - 1)) begin
            filt_q <= sync_q[1];
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign line_o = filt_q;

   AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_q) |-> filt_q == $past(sync_q[1])); // R11

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file #(
   parameter int NREG    = 4,
   parameter int MWE_REG = 2,
   parameter int MWE_BIT = 0,
   localparam int SELW   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SELW-1:0]   wr_sel,
   input  logic [7:0]        wr_data,
   input  logic [SELW-1:0]   rd_sel,
   output logic [7:0]        rd_data,
   output logic              mass_en,
   output logic [NREG*8-1:0] regs_o
);
   if (MWE_REG >= NREG || MWE_BIT > 7) begin : g_bad_mwe
      $error("mass-write enable bit lies outside the register file");
   end

   function automatic logic [NREG*8-1:0] reset_image();
      logic [NREG*8-1:0] img;
      img = '0;
      for (int i = 0; i < NREG; i++) begin
         if (i == MWE_REG) img[i*8 +: 8] = 8'(1 << MWE_BIT);
      end
      return img;
   endfunction

   localparam logic [NREG*8-1:0] RST_IMG = reset_image();

   logic [NREG*8-1:0] regs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= RST_IMG;
      end else if (wr_en) begin
         regs_q[{wr_sel, 3'b000} +: 8] <= wr_data;
      end
   end

   assign rd_data = regs_q[{rd_sel, 3'b000} +: 8];
   assign mass_en = regs_q[MWE_REG*8 + MWE_BIT];
   assign regs_o  = regs_q;

   AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_q)); // R3

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
   import smb_pkg::*;
#(
   parameter int NREG  = 4,
   localparam int SELW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_f,
   input  logic            sda_f,
   input  logic [6:0]      dev_addr,
   input  logic            mass_en,
   input  logic            alert_set,
   input  logic [7:0]      rd_data,
   output logic [SELW-1:0] rd_sel,
   output logic            wr_en,
   output logic [SELW-1:0] wr_sel,
   output logic [7:0]      wr_data,
   output logic            sda_oe,
   output logic            alert_pending
);
   smb_state_t      state, after_ack;
   logic            scl_d, sda_d;
   logic [2:0]      bit_cnt;
   logic            byte_rdy;
   logic [7:0]      shreg, txreg;
   logic            ara_mode;
   logic [SELW-1:0] ptr;
   logic            pend_valid;
   logic [SELW-1:0] pend_sel;
   logic [7:0]      pend_data;
   logic            alert_q;

   logic start_c, stop_c, rise, fall, ara_win_c, lost_c;
   logic [6:0] rx_addr;
   logic       rx_rd;

   assign start_c = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_c  = scl_f & scl_d & ~sda_d & sda_f;
   assign rise    = scl_f & ~scl_d;
   assign fall    = ~scl_f & scl_d;
   assign rx_addr = shreg[7:1];
   assign rx_rd   = shreg[0];

   assign lost_c    = (state == ST_TX) && ara_mode && rise && txreg[7] && !sda_f;
   assign ara_win_c = (state == ST_TX) && ara_mode && rise && (bit_cnt == 3'd7)
                      && !lost_c && !start_c && !stop_c;

   assign wr_en         = stop_c & pend_valid;
   assign wr_sel        = pend_sel;
   assign wr_data       = pend_data;
   assign rd_sel        = ptr;
   assign alert_pending = alert_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         after_ack  <= ST_IDLE;
         scl_d      <= 1'b1;
         sda_d      <= 1'b1;
         bit_cnt    <= '0;
         byte_rdy   <= 1'b0;
         shreg      <= '0;
         txreg      <= '0;
         ara_mode   <= 1'b0;
         ptr        <= '0;
         pend_valid <= 1'b0;
         pend_sel   <= '0;
         pend_data  <= '0;
         sda_oe     <= 1'b0;
         alert_q    <= 1'b0;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;

         if (alert_set)      alert_q <= 1'b1;
         else if (ara_win_c) alert_q <= 1'b0;

         if (stop_c) begin
            state      <= ST_IDLE;
            sda_oe     <= 1'b0;
            pend_valid <= 1'b0;
            ara_mode   <= 1'b0;
         end else if (start_c) begin
            state      <= ST_ADDR;
            bit_cnt    <= '0;
            byte_rdy   <= 1'b0;
            sda_oe     <= 1'b0;
            pend_valid <= 1'b0;
            ara_mode   <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_CMD, ST_WDAT: begin
                  if (rise) begin
                     shreg   <= {shreg[6:0], sda_f};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) byte_rdy <= 1'b1;
                  end else if (fall && byte_rdy) begin
                     byte_rdy <= 1'b0;
                     if (state == ST_ADDR) begin
                        if (rx_addr == dev_addr) begin
                           sda_oe    <= 1'b1;
                           state     <= ST_ACK;
                           after_ack <= rx_rd ? ST_TX : ST_CMD;
                           txreg     <= rd_data;
                        end else if (rx_addr == BCAST_ADDR && !rx_rd && mass_en) begin
                           sda_oe    <= 1'b1;
                           state     <= ST_ACK;
                           after_ack <= ST_CMD;
                        end else if (rx_addr == ALERT_ADDR && rx_rd && alert_q) begin
                           sda_oe    <= 1'b1;
                           state     <= ST_ACK;
                           after_ack <= ST_TX;
                           txreg     <= {dev_addr, 1'b1};
                           ara_mode  <= 1'b1;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else if (state == ST_CMD) begin
                        ptr       <= shreg[SELW-1:0];
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ST_WDAT;
                     end else begin
                        pend_sel   <= ptr;
                        pend_data  <= shreg;
                        pend_valid <= 1'b1;
                        sda_oe     <= 1'b1;
                        state      <= ST_ACK;
                        after_ack  <= ST_SKIP;
                     end
                  end
               end
               ST_ACK: begin
                  if (fall) begin
                     sda_oe  <= (after_ack == ST_TX) ? ~txreg[7] : 1'b0;
                     state   <= after_ack;
                     bit_cnt <= '0;
                  end
               end
               ST_TX: begin
                  if (lost_c) begin
                     sda_oe <= 1'b0;
                     state  <= ST_SKIP;
                  end else if (rise) begin
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) byte_rdy <= 1'b1;
                  end else if (fall) begin
                     if (byte_rdy) begin
                        byte_rdy <= 1'b0;
                        sda_oe   <= 1'b0;
                        state    <= ST_SKIP;
                     end else begin
                        txreg  <= {txreg[6:0], 1'b0};
                        sda_oe <= ~txreg[6];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe); // R6

   AST_START_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> !pend_valid); // R4

   AST_ALERT_CLEARS_ON_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alert_q) |-> $past(ara_mode) && $past(state == ST_TX)); // R9

   AST_LOSER_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_c && !start_c && !stop_c) |=> !sda_oe && alert_q); // R10

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
   parameter int NREG     = 4,
   parameter int FILT_CYC = 7,
   parameter int MWE_REG  = 2,
   parameter int MWE_BIT  = 0,
   localparam int SELW    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [6:0]        dev_addr,
   input  logic              alert_set,
   output logic              alert_pending,
   output logic [NREG*8-1:0] ctrl_regs
);
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end

   logic [1:0] line_raw, line_flt;
   assign line_raw = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      smb_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(line_raw[g]),
         .line_o(line_flt[g])
      );
   end

   logic            wr_en, mass_en;
   logic [SELW-1:0] wr_sel, rd_sel;
   logic [7:0]      wr_data, rd_data;

   smb_target_fsm #(.NREG(NREG)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_f        (line_flt[1]),
      .sda_f        (line_flt[0]),
      .dev_addr     (dev_addr),
      .mass_en      (mass_en),
      .alert_set    (alert_set),
      .rd_data      (rd_data),
      .rd_sel       (rd_sel),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .sda_oe       (sda_oe),
      .alert_pending(alert_pending)
   );

   smb_reg_file #(.NREG(NREG), .MWE_REG(MWE_REG), .MWE_BIT(MWE_BIT)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .rd_sel (rd_sel),
      .rd_data(rd_data),
      .mass_en(mass_en),
      .regs_o (ctrl_regs)
   );

endmodule

// File: tb/smb_regbank_test.sv
module smb_regbank_test;
   localparam int Q = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1, sda_other = 1'b1, glitch = 1'b0;
   logic alert_set = 1'b0;
   logic sda_oe, alert_pending;
   logic [31:0] ctrl_regs;
   logic [6:0] dev_addr = 7'h42;

   wire scl_line = scl_m ^ glitch;
   wire sda_line = sda_m & sda_other & ~sda_oe;

   smb_regbank uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .sda_oe(sda_oe), .dev_addr(dev_addr), .alert_set(alert_set),
      .alert_pending(alert_pending), .ctrl_regs(ctrl_regs)
   );

   int vectors = 0, miscompares = 0;
   bit done = 0;
   logic [31:0] exp_img;
   logic watch = 1'b0, oe_seen = 1'b0;

   always @(negedge clk) if (watch && sda_oe === 1'b1) oe_seen = 1'b1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic qw; repeat (Q) @(negedge clk); endtask

   task automatic bus_start;
      sda_m = 1'b1; qw; scl_m = 1'b1; qw; sda_m = 1'b0; qw; scl_m = 1'b0; qw;
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; qw; scl_m = 1'b1; qw; sda_m = 1'b1; qw; qw;
   endtask

   task automatic wbit(input logic b, input logic gl);
      sda_m = b; qw; scl_m = 1'b1; qw; qw; scl_m = 1'b0;
      repeat (10) @(negedge clk);
      if (gl) begin
         glitch = 1'b1; repeat (3) @(negedge clk); glitch = 1'b0;
      end
      qw;
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; qw; scl_m = 1'b1; qw; b = sda_line; qw; scl_m = 1'b0; qw;
   endtask

   task automatic wbyte(input logic [7:0] v, input logic gl, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(v[i], gl);
      rbit(b);
      ack = ~b;
   endtask

   task automatic rbyte(output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
      wbit(1'b1, 1'b0);
   endtask

   task automatic write_txn(input logic [6:0] a, input logic [7:0] cmd,
                            input logic [7:0] dat, output logic [2:0] acks);
      bus_start;
      wbyte({a, 1'b0}, 1'b0, acks[2]);
      if (acks[2]) begin
         wbyte(cmd, 1'b0, acks[1]);
         wbyte(dat, 1'b0, acks[0]);
      end else acks[1:0] = 2'b00;
      bus_stop;
   endtask

   task automatic read_txn(input logic [7:0] cmd, output logic [7:0] v);
      logic a0, a1, a2;
      bus_start;
      wbyte({dev_addr, 1'b0}, 1'b0, a0);
      wbyte(cmd, 1'b0, a1);
      bus_start;
      wbyte({dev_addr, 1'b1}, 1'b0, a2);
      rbyte(v);
      bus_stop;
      check("R5 read acks", {29'd0, a0, a1, a2}, 32'd7);
   endtask

   initial begin
      logic [2:0] acks;
      logic [7:0] v;
      logic a, b;
      exp_img = 32'h0001_0000;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R12 reset state
      check("R12 regs", ctrl_regs, exp_img);
      check("R12 oe/alert", {30'd0, sda_oe, alert_pending}, 32'd0);

      // R1/R3 write, sampled before and after STOP
      bus_start;
      wbyte({dev_addr, 1'b0}, 1'b0, acks[2]);
      wbyte(8'h01, 1'b0, acks[1]);
      wbyte(8'hA5, 1'b0, acks[0]);
      check("R3 before stop", ctrl_regs, exp_img);
      bus_stop;
      exp_img[15:8] = 8'hA5;
      check("R1 acks", {29'd0, acks}, 32'd7);
      check("R1 commit", ctrl_regs, exp_img);

      // R2 upper command bits ignored
      write_txn(dev_addr, 8'hFF, 8'h3C, acks);
      exp_img[31:24] = 8'h3C;
      check("R2 cmd FF", ctrl_regs, exp_img);
      write_txn(dev_addr, 8'hFC, 8'h11, acks);
      exp_img[7:0] = 8'h11;
      check("R2 cmd FC", ctrl_regs, exp_img);

      // R5 read back
      read_txn(8'h01, v);
      check("R5 reg1", {24'd0, v}, 32'h0000_00A5);
      read_txn(8'hF7, v);
      check("R5 R2 reg3", {24'd0, v}, 32'h0000_003C);

      // R4 repeated START discards pending write
      bus_start;
      wbyte({dev_addr, 1'b0}, 1'b0, a);
      wbyte(8'h00, 1'b0, a);
      wbyte(8'h77, 1'b0, a);
      bus_start;
      wbyte({dev_addr, 1'b1}, 1'b0, a);
      rbyte(v);
      bus_stop;
      check("R4 regs kept", ctrl_regs, exp_img);
      check("R4 R5 read old", {24'd0, v}, 32'h0000_0011);

      // R6 unmatched address
      oe_seen = 1'b0; watch = 1'b1;
      write_txn(7'h43, 8'h00, 8'hEE, acks);
      watch = 1'b0;
      check("R6 no ack", {29'd0, acks}, 32'd0);
      check("R6 oe never", {31'd0, oe_seen}, 32'd0);
      check("R6 regs", ctrl_regs, exp_img);

      // R7 broadcast write
      write_txn(7'b1011110, 8'h01, 8'h5A, acks);
      exp_img[15:8] = 8'h5A;
      check("R7 acks", {29'd0, acks}, 32'd7);
      check("R7 regs", ctrl_regs, exp_img);
      write_txn(7'b1011110, 8'h02, 8'h00, acks);
      exp_img[23:16] = 8'h00;
      check("R7 clear enable", ctrl_regs, exp_img);

      // R8 broadcast blocked
      write_txn(7'b1011110, 8'h01, 8'h99, acks);
      check("R8 no ack", {29'd0, acks}, 32'd0);
      check("R8 regs", ctrl_regs, exp_img);
      write_txn(dev_addr, 8'h02, 8'h01, acks);
      exp_img[23:16] = 8'h01;
      check("R1 re-enable", ctrl_regs, exp_img);

      // R9 alert response
      bus_start;
      wbyte({7'b0001100, 1'b1}, 1'b0, a);
      bus_stop;
      check("R9 no alert no ack", {31'd0, a}, 32'd0);
      @(negedge clk) alert_set = 1'b1;
      @(negedge clk) alert_set = 1'b0;
      check("R9 alert raised", {31'd0, alert_pending}, 32'd1);
      bus_start;
      wbyte({7'b0001100, 1'b1}, 1'b0, a);
      rbyte(v);
      bus_stop;
      check("R9 ack", {31'd0, a}, 32'd1);
      check("R9 byte", {24'd0, v}, {24'd0, dev_addr, 1'b1});
      check("R9 alert cleared", {31'd0, alert_pending}, 32'd0);

      // R10 lost arbitration against address 7'h21
      @(negedge clk) alert_set = 1'b1;
      @(negedge clk) alert_set = 1'b0;
      bus_start;
      wbyte({7'b0001100, 1'b1}, 1'b0, a);
      for (int i = 7; i >= 0; i--) begin
         sda_other = {7'h21, 1'b1} >> i;
         rbit(b);
         v[i] = b;
      end
      sda_other = 1'b1;
      wbit(1'b1, 1'b0);
      bus_stop;
      check("R10 byte from winner", {24'd0, v}, 32'h0000_0043);
      check("R10 alert kept", {31'd0, alert_pending}, 32'd1);

      // R11 SCL spike during data byte
      bus_start;
      wbyte({dev_addr, 1'b0}, 1'b0, a);
      wbyte(8'h03, 1'b0, a);
      wbyte(8'h96, 1'b1, a);
      bus_stop;
      exp_img[31:24] = 8'h96;
      check("R11 spike ignored", ctrl_regs, exp_img);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         done = 1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule